// File: doc/BRIEF.md
# Dual-Format Serial Management Slave

This block is the slave end of a two-wire serial management bus, clocked by the management clock and attached to the shared bidirectional data line through a separate input, output and output-enable. It listens for frames in two formats. The short format carries a 5-bit port address and a 5-bit register address. The extended format carries a 5-bit port address, a 5-bit device address and a 16-bit address or data word. A single parser decodes both formats, telling them apart by the start code.

The port address is compared with strap inputs, and the device address of extended frames is compared with a parameter. When a frame matches, the slave issues a one-cycle read or write request on a local register interface. For reads it drives the turnaround zero and the 16 data bits back onto the line. Extended frames use a local 16-bit address register. An address frame loads it, and a read-with-increment frame returns data and then advances it.

Top module: `mdio_dual_slave`

## Requirements
- R1: After reset the line is not driven (`mdio_oe`=0) and neither `reg_rd` nor `reg_wr` is asserted.
- R2: A frame is decoded only when at least PRE_LEN (32) consecutive ones precede the start bit 0. A frame preceded by only 31 ones produces no request and no drive.
- R3: A short read (start 01, op 10) pulses `reg_rd` with `reg_ext`=0 and `reg_addr`={11'b0, register field}. The slave drives 0 in the second turnaround bit and then `reg_rdata` most significant bit first, one bit per clock, changing after the rising edge. It releases the line after the last bit, for a drive window of 17 cycles.
- R4: A short write (start 01, op 01) pulses `reg_wr` once after the last data bit, with `reg_ext`=0, the register field as address and the 16 data bits as `reg_wdata`.
- R5: A frame whose port field differs from `port_strap` produces no request and never drives the line.
- R6: An extended address frame (start 00, op 00) loads its 16-bit data field into the address register and issues no request.
- R7: An extended write (start 00, op 01) pulses `reg_wr` with `reg_ext`=1 and `reg_addr` equal to the address register.
- R8: An extended read (start 00, op 11) returns `reg_rdata` for the address register and leaves that register unchanged.
- R9: An extended read-with-increment (start 00, op 10) returns data for the current address and then adds one to it. The address wraps from 0xFFFF to 0x0000.
- R10: An extended frame whose device field differs from DEV_ADDR is ignored, with no request and no drive.
- R11: A short frame with op 00 or 11 is malformed. It is ignored, and the slave waits for a fresh preamble.
- R12: A write or address frame whose turnaround bits are not 1 then 0 is dropped, with no write and no address load.
- R13: `reg_rd` and `reg_wr` are single-cycle pulses and never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; data line sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Data line value seen by the slave |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| port_strap | input | 5 | This device's port address |
| reg_rd | output | 1 | One-cycle read request |
| reg_wr | output | 1 | One-cycle write request |
| reg_ext | output | 1 | 1 for extended-format access, 0 for short |
| reg_addr | output | 16 | Register address of the request |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid in the cycle `reg_rd` is high |

## Verification
The hardest state to reach is the read-with-increment wrap. The address register has no direct load path from the ports, so the bench first sends an extended address frame with 0xFFFE. It then issues three increment reads in a row and confirms, through the returned data and a following extended write, that the address passed through 0xFFFF to 0x0000. Dropped frames, whether malformed opcodes, bad turnaround bits or short preambles, are checked the same way. A follow-up write exposes whether the address register or the parser state was disturbed.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FLD_W  = 5;
  localparam int WORD_W = 16;
  localparam int HDR_W  = 13;

  typedef enum logic [1:0] {S_PRE, S_HDR, S_TA, S_DATA} rx_state_t;
  typedef enum logic [1:0] {K_RD, K_WR, K_ADDR, K_RDINC} kind_t;

  localparam logic [1:0] SOP_RD    = 2'b10;
  localparam logic [1:0] SOP_WR    = 2'b01;
  localparam logic [1:0] XOP_ADDR  = 2'b00;
  localparam logic [1:0] XOP_WR    = 2'b01;
  localparam logic [1:0] XOP_RD    = 2'b11;
  localparam logic [1:0] XOP_RDINC = 2'b10;
endpackage

// File: rtl/mdio_preamble_det.sv
`timescale 1ns/1ps
module mdio_preamble_det #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic bit_in,
  output logic ok
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm || !bit_in) cnt <= '0;
    else if (cnt != CW'(LEN)) cnt <= cnt + 1'b1;
  end

  assign ok = (cnt == CW'(LEN));
endmodule

// File: rtl/mdio_ext_addr.sv
`timescale 1ns/1ps
module mdio_ext_addr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/mdio_tx_shift.sv
`timescale 1ns/1ps
module mdio_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         release_line,
  output logic         o,
  output logic         oe
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      o  <= 1'b0;
      oe <= 1'b0;
    end else if (load) begin
      sh <= load_val;
      o  <= 1'b0;
      oe <= 1'b1;
    end else if (shift) begin
      o  <= sh[W-1];
      sh <= {sh[W-2:0], 1'b0};
    end else if (release_line) begin
      o  <= 1'b0;
      oe <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_dual_slave.sv
`timescale 1ns/1ps
module mdio_dual_slave
  import mdio_pkg::*;
#(
  parameter int          PRE_LEN  = 32,
  parameter logic [4:0]  DEV_ADDR = 5'd3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mdio_i,
  output logic                mdio_o,
  output logic                mdio_oe,
  input  logic [FLD_W-1:0]    port_strap,
  output logic                reg_rd,
  output logic                reg_wr,
  output logic                reg_ext,
  output logic [WORD_W-1:0]   reg_addr,
  output logic [WORD_W-1:0]   reg_wdata,
  input  logic [WORD_W-1:0]   reg_rdata
);
  localparam int HC_W = $clog2(HDR_W);
  localparam int BC_W = $clog2(WORD_W);

  rx_state_t         state;
  logic [HC_W-1:0]   hdr_cnt;
  logic [HDR_W-2:0]  hdr_sh;
  logic [BC_W-1:0]   bit_cnt;
  logic [WORD_W-2:0] rx_sh;
  kind_t             kind;
  logic              pre_ok;
  logic [WORD_W-1:0] ext_addr;

  // header decode, valid on the edge that samples the last header bit
  logic [HDR_W-1:0]  full_hdr;
  logic              h_short;
  logic [1:0]        h_op;
  logic [FLD_W-1:0]  h_port, h_fld;
  logic              h_valid;
  kind_t             h_kind;

  always_comb begin
    full_hdr = {hdr_sh, mdio_i};
    h_short  = full_hdr[12];
    h_op     = full_hdr[11:10];
    h_port   = full_hdr[9:5];
    h_fld    = full_hdr[4:0];
    h_valid  = 1'b0;
    h_kind   = K_RD;
    if (h_short) begin
      if (h_op == SOP_RD)      begin h_valid = 1'b1; h_kind = K_RD; end
      else if (h_op == SOP_WR) begin h_valid = 1'b1; h_kind = K_WR; end
    end else if (h_fld == DEV_ADDR) begin
      h_valid = 1'b1;
      case (h_op)
        XOP_ADDR:  h_kind = K_ADDR;
        XOP_WR:    h_kind = K_WR;
        XOP_RD:    h_kind = K_RD;
        default:   h_kind = K_RDINC;
      endcase
    end
  end

  logic accept, is_read, last_bit;
  logic tx_load, tx_shift, tx_release;
  logic addr_load, addr_inc;

  assign accept   = (state == S_HDR) && (hdr_cnt == HC_W'(HDR_W - 1)) &&
                    h_valid && (h_port == port_strap);
  assign is_read  = (kind == K_RD) || (kind == K_RDINC);
  assign last_bit = (state == S_DATA) && (bit_cnt == BC_W'(WORD_W - 1));

  assign tx_load    = (state == S_TA) && (bit_cnt == '0) && is_read;
  assign tx_shift   = is_read && (((state == S_TA) && (bit_cnt != '0)) ||
                                  ((state == S_DATA) && !last_bit));
  assign tx_release = is_read && last_bit;
  assign addr_load  = last_bit && (kind == K_ADDR);
  assign addr_inc   = last_bit && (kind == K_RDINC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PRE;
      hdr_cnt   <= '0;
      hdr_sh    <= '0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      kind      <= K_RD;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_ext   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      case (state)
        S_PRE: begin
          if (pre_ok && !mdio_i) begin
            state   <= S_HDR;
            hdr_cnt <= '0;
          end
        end
        S_HDR: begin
          hdr_sh  <= full_hdr[HDR_W-2:0];
          hdr_cnt <= hdr_cnt + 1'b1;
          if (hdr_cnt == HC_W'(HDR_W - 1)) begin
            if (accept) begin
              state    <= S_TA;
              bit_cnt  <= '0;
              kind     <= h_kind;
              reg_ext  <= !h_short;
              reg_addr <= h_short ? {{(WORD_W-FLD_W){1'b0}}, h_fld} : ext_addr;
              reg_rd   <= (h_kind == K_RD) || (h_kind == K_RDINC);
            end else begin
              state <= S_PRE;
            end
          end
        end
        S_TA: begin
          if (bit_cnt == '0) begin
            if (!is_read && !mdio_i) state <= S_PRE;
            else bit_cnt <= bit_cnt + 1'b1;
          end else begin
            if (!is_read && mdio_i) state <= S_PRE;
            else begin
              state   <= S_DATA;
              bit_cnt <= '0;
            end
          end
        end
        default: begin
          rx_sh   <= {rx_sh[WORD_W-3:0], mdio_i};
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) begin
            state <= S_PRE;
            if (kind == K_WR) begin
              reg_wr    <= 1'b1;
              reg_wdata <= {rx_sh, mdio_i};
            end
          end
        end
      endcase
    end
  end

  mdio_preamble_det #(.LEN(PRE_LEN)) u_pre (
    .clk(clk), .rst(rst), .arm(state == S_PRE), .bit_in(mdio_i), .ok(pre_ok)
  );

  mdio_ext_addr #(.W(WORD_W)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .load_val({rx_sh, mdio_i}),
    .inc(addr_inc), .addr(ext_addr)
  );

  mdio_tx_shift #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_val(reg_rdata),
    .shift(tx_shift), .release_line(tx_release), .o(mdio_o), .oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_dual_slave_chk.sv
`timescale 1ns/1ps
module mdio_dual_slave_chk (
  input logic clk,
  input logic rst,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_rd,
  input logic reg_wr
);
  logic [5:0] oe_run;
  always_ff @(posedge clk) begin
    if (rst || !mdio_oe) oe_run <= '0;
    else if (oe_run != 6'h3F) oe_run <= oe_run + 1'b1;
  end

  a_r13_excl: assert property (@(posedge clk) disable iff (rst) !(reg_rd && reg_wr));
  a_r13_rd_pulse: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd);
  a_r13_wr_pulse: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr);
  // R3 and R5: drive begins only right after a read request
  a_r3_drive_after_rd: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $past(reg_rd));
  a_r3_ta_zero: assert property (@(posedge clk) disable iff (rst) $rose(mdio_oe) |-> !mdio_o);
  a_r3_drive_len: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> (oe_run == 6'd17));
  a_r1_no_wr_while_drive: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> !reg_wr);
endmodule

bind mdio_dual_slave mdio_dual_slave_chk u_chk (
  .clk(clk), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/mdio_dual_slave_bench.sv
`timescale 1ns/1ps
module mdio_dual_slave_bench;
  localparam logic [4:0] STRAP = 5'h09;
  localparam logic [4:0] DEV   = 5'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mdio_in = 1'b1;
  logic mdio_o, mdio_oe, reg_rd, reg_wr, reg_ext;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  mdio_dual_slave #(.PRE_LEN(32), .DEV_ADDR(DEV)) u_mdio_dual_slave (
    .clk(clk), .rst(rst), .mdio_i(mdio_in), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .port_strap(STRAP), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_ext(reg_ext),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic e);
    return {a[7:0], a[15:8]} ^ (e ? 16'h5A3C : 16'h00C3);
  endfunction
  assign reg_rdata = model(reg_addr, reg_ext);

  int errors = 0, checks = 0;
  bit done = 0;

  int rd_n, wr_n, oe_n;
  logic [15:0] rd_addr, wr_addr, wr_data, rdval;
  logic rd_ext, wr_ext, ta_ok, early_oe, late_oe;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    if (reg_rd) begin rd_n++; rd_addr = reg_addr; rd_ext = reg_ext; end
    if (reg_wr) begin wr_n++; wr_addr = reg_addr; wr_data = reg_wdata; wr_ext = reg_ext; end
    if (mdio_oe) oe_n++;
    mdio_in = b;
  endtask

  task automatic frame(input logic st1, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] fld, input logic [1:0] ta,
                       input logic [15:0] data, input int pre_n);
    logic [31:0] body;
    body = {1'b0, st1, op, pa, fld, ta, data};
    rd_n = 0; wr_n = 0; oe_n = 0; rdval = '0;
    ta_ok = 0; early_oe = 0; late_oe = 0;
    step(1'b0);
    for (int i = 0; i < pre_n; i++) step(1'b1);
    for (int i = 0; i < 32; i++) begin
      step(body[31-i]);
      if (i <= 14 && mdio_oe) early_oe = 1;
      if (i == 15) ta_ok = mdio_oe && !mdio_o;
      if (i >= 16) rdval[31-i] = mdio_o;
    end
    step(1'b1);
    late_oe = mdio_oe;
    step(1'b1);
    step(1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 oe", mdio_oe, 0);
    chk("R1 rd", reg_rd, 0);
    chk("R1 wr", reg_wr, 0);
  endtask

  task automatic t_short_write;
    frame(1, 2'b01, STRAP, 5'h0D, 2'b10, 16'h1234, 32);
    chk("R4 wr count", wr_n, 1);
    chk("R4 addr", wr_addr, 16'h000D);
    chk("R4 data", wr_data, 16'h1234);
    chk("R4 ext", wr_ext, 0);
    chk("R4 no drive", oe_n, 0);
  endtask

  task automatic t_short_read;
    frame(1, 2'b10, STRAP, 5'h03, 2'b11, 16'hFFFF, 32);
    chk("R3 rd count", rd_n, 1);
    chk("R3 addr", rd_addr, 16'h0003);
    chk("R3 ext", rd_ext, 0);
    chk("R3 ta drive 0", ta_ok, 1);
    chk("R3 data", rdval, model(16'h0003, 0));
    chk("R3 no early drive", early_oe, 0);
    chk("R3 released", late_oe, 0);
    chk("R3 drive cycles", oe_n, 17);
  endtask

  task automatic t_port_mismatch;
    frame(1, 2'b01, STRAP ^ 5'h01, 5'h02, 2'b10, 16'hAAAA, 32);
    chk("R5 write ignored", wr_n, 0);
    frame(1, 2'b10, 5'h1F, 5'h02, 2'b11, 16'hFFFF, 32);
    chk("R5 read no request", rd_n, 0);
    chk("R5 read no drive", oe_n, 0);
  endtask

  task automatic t_ext_addr_write;
    frame(0, 2'b00, STRAP, DEV, 2'b10, 16'h0100, 32);
    chk("R6 no request", rd_n + wr_n, 0);
    chk("R6 no drive", oe_n, 0);
    frame(0, 2'b01, STRAP, DEV, 2'b10, 16'hBEEF, 32);
    chk("R7 wr count", wr_n, 1);
    chk("R7 addr from R6 load", wr_addr, 16'h0100);
    chk("R7 data", wr_data, 16'hBEEF);
    chk("R7 ext", wr_ext, 1);
  endtask

  task automatic t_ext_read;
    frame(0, 2'b11, STRAP, DEV, 2'b11, 16'hFFFF, 32);
    chk("R8 rd addr", rd_addr, 16'h0100);
    chk("R8 ext", rd_ext, 1);
    chk("R8 data", rdval, model(16'h0100, 1));
    frame(0, 2'b01, STRAP, DEV, 2'b10, 16'h0001, 32);
    chk("R8 addr unchanged", wr_addr, 16'h0100);
  endtask

  task automatic t_rdinc_wrap;
    frame(0, 2'b00, STRAP, DEV, 2'b10, 16'hFFFE, 32);
    frame(0, 2'b10, STRAP, DEV, 2'b11, 16'hFFFF, 32);
    chk("R9 first data", rdval, model(16'hFFFE, 1));
    frame(0, 2'b10, STRAP, DEV, 2'b11, 16'hFFFF, 32);
    chk("R9 incremented addr", rd_addr, 16'hFFFF);
    chk("R9 second data", rdval, model(16'hFFFF, 1));
    frame(0, 2'b10, STRAP, DEV, 2'b11, 16'hFFFF, 32);
    chk("R9 wrap addr", rd_addr, 16'h0000);
    chk("R9 wrap data", rdval, model(16'h0000, 1));
    frame(0, 2'b01, STRAP, DEV, 2'b10, 16'h7777, 32);
    chk("R9 addr after wrap", wr_addr, 16'h0001);
  endtask

  task automatic t_dev_mismatch;
    frame(0, 2'b01, STRAP, DEV + 5'd1, 2'b10, 16'h4444, 32);
    chk("R10 write ignored", wr_n, 0);
    frame(0, 2'b11, STRAP, 5'd0, 2'b11, 16'hFFFF, 32);
    chk("R10 read no request", rd_n, 0);
    chk("R10 read no drive", oe_n, 0);
  endtask

  task automatic t_preamble;
    frame(1, 2'b01, STRAP, 5'h05, 2'b10, 16'h5555, 31);
    chk("R2 31 ones ignored", wr_n, 0);
    frame(1, 2'b01, STRAP, 5'h05, 2'b10, 16'h5555, 32);
    chk("R2 32 ones accepted", wr_n, 1);
  endtask

  task automatic t_bad_op;
    frame(1, 2'b11, STRAP, 5'h04, 2'b10, 16'h1111, 32);
    chk("R11 op 11 ignored", rd_n + wr_n + oe_n, 0);
    frame(1, 2'b00, STRAP, 5'h04, 2'b11, 16'hFFFF, 32);
    chk("R11 op 00 ignored", rd_n + wr_n + oe_n, 0);
    frame(1, 2'b01, STRAP, 5'h06, 2'b10, 16'h2222, 32);
    chk("R11 recovery write", wr_data, 16'h2222);
  endtask

  task automatic t_bad_ta;
    frame(1, 2'b01, STRAP, 5'h07, 2'b11, 16'h3333, 32);
    chk("R12 ta 11 dropped", wr_n, 0);
    frame(1, 2'b01, STRAP, 5'h07, 2'b00, 16'h3333, 32);
    chk("R12 ta 00 dropped", wr_n, 0);
    frame(0, 2'b00, STRAP, DEV, 2'b01, 16'h9999, 32);
    frame(0, 2'b01, STRAP, DEV, 2'b10, 16'h0002, 32);
    chk("R12 address not loaded", wr_addr, 16'h0001);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_short_write();
    t_short_read();
    t_port_mismatch();
    t_ext_addr_write();
    t_ext_read();
    t_rdinc_wrap();
    t_dev_mismatch();
    t_preamble();
    t_bad_op();
    t_bad_ta();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule